// File: doc/BRIEF.md
# Clause-22 Management Frame Master

This block drives the MDC clock and MDIO data pins of a clause-22 management interface. A transaction starts from one write of a 32-bit command word. The word holds the start code, the opcode, the PHY address, the register address, the turnaround field and 16 data bits. The block first sends a run of preamble ones. It then shifts out the command word, most significant bit first. On a read it releases the data pin for the PHY to answer. When the frame ends, the 16 bits captured from the PHY replace the low half of the command register. A sticky completion flag is then set, and it can serve as an interrupt source.

The MDC rate comes from a divider value that software writes pre-shifted by one bit. Bits 7:1 of that value form the half-period count N, so MDC runs at f_clk / (2·N). Bit 0 is ignored. When N is zero, MDC is stopped and MDIO stays idle. The pad and the PHY lie outside the block: the block provides a data output, an output enable and a data input.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, mdc is 0, mdio_oe is 0, busy is 0, done_evt is 0 and cmd_rdata is 0.
- R2: Every frame begins with 32 MDC cycles during which mdio_o is 1 and mdio_oe is 1.
- R3: After the preamble, the driven bits at each MDC rising edge match the written command word from bit 31 down to bit 0. For a write (bits 29:28 = 01), all 32 bits are driven and cmd_rdata keeps the written word after the frame.
- R4: The MDC period is 2·N clock cycles, where N = div_wdata[7:1]. Bit 0 of the divider value has no effect on the rate.
- R5: On a read (bits 29:28 = 10), mdio_oe is high for frame bits 0 to 46 and low for bits 47 to 63, that is, from the second turnaround bit to the end of the frame.
- R6: On a read, mdio_i is sampled at the MDC rising edge of each of the last 16 frame bits, MSB first. After the frame these bits appear in cmd_rdata[15:0], and cmd_rdata[31:16] keeps the written value.
- R7: When a frame finishes, busy falls and done_evt is set in the same cycle. done_evt stays set until an evt_clr pulse clears it.
- R8: A cmd_wr while busy is high is ignored: neither cmd_rdata nor the frame in progress changes.
- R9: While N is zero, MDC does not toggle, mdio_oe stays 0 and a pending frame holds. The frame resumes once N becomes non-zero.
- R10: busy rises in the cycle after an accepted cmd_wr and stays high until the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word: start, opcode, PHY address, register address, turnaround, data |
| div_wr | input | 1 | Write strobe for the divider value |
| div_wdata | input | 8 | Pre-shifted divider value; bits 7:1 form N |
| evt_clr | input | 1 | Clears the completion flag |
| cmd_rdata | output | 32 | Command register; holds read data in bits 15:0 after a read |
| busy | output | 1 | Frame in progress |
| done_evt | output | 1 | Sticky completion flag |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data driven toward the pad |
| mdio_oe | output | 1 | Pad output enable |
| mdio_i | input | 1 | Data received from the pad |

## Verification
The case hardest to reach from the ports is a command write that arrives while a frame is on the wire. The write has to land after MDC has started and before the last bit. The stimulus waits for a fixed number of MDC rising edges into a write frame, issues a second, different command, and then compares the whole captured frame and cmd_rdata with the first command. A frozen divider is handled in a similar way: the bench queues a frame with N at zero, watches the pins for many cycles, and then releases the divider and checks that the frame completes intact.

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_wdata,
  input  logic              div_wr,
  input  logic [DIV_W-1:0]  div_wdata,
  input  logic              evt_clr,
  output logic [31:0]       cmd_rdata,
  output logic              busy,
  output logic              done_evt,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int FW    = DIV_W - 1;
  localparam int FRAME = PRE_LEN + 32;
  localparam int CW    = $clog2(FRAME + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(FRAME - 1);
  localparam logic [CW-1:0] CMD_BIT  = CW'(PRE_LEN);
  localparam logic [CW-1:0] REL_BIT  = CW'(PRE_LEN + 15);
  localparam logic [CW-1:0] DAT_BIT  = CW'(PRE_LEN + 16);

  logic [31:0]   cmd_q, sh_q;
  logic [15:0]   rd_q;
  logic [FW-1:0] field_q, hcnt_q;
  logic [CW-1:0] bit_q;
  logic          busy_q, mdc_q, evt_q, rd_op_q;

  wire unused_lsb = div_wdata[0];

  wire run    = busy_q && (field_q != '0);
  wire tick   = run && (hcnt_q >= field_q - 1'b1);
  wire rise   = tick && !mdc_q;
  wire fall   = tick && mdc_q;
  wire last   = fall && (bit_q == LAST_BIT);
  wire accept = cmd_wr && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      sh_q    <= '0;
      rd_q    <= '0;
      field_q <= '0;
      hcnt_q  <= '0;
      bit_q   <= '0;
      busy_q  <= 1'b0;
      mdc_q   <= 1'b0;
      evt_q   <= 1'b0;
      rd_op_q <= 1'b0;
    end else begin
      if (div_wr) field_q <= div_wdata[DIV_W-1:1];
      hcnt_q <= (!run || tick) ? '0 : hcnt_q + 1'b1;

      if (accept) begin
        cmd_q   <= cmd_wdata;
        sh_q    <= cmd_wdata;
        rd_op_q <= (cmd_wdata[29:28] == 2'b10);
        busy_q  <= 1'b1;
        bit_q   <= '0;
        mdc_q   <= 1'b0;
      end else begin
        if (tick) mdc_q <= ~mdc_q;
        if (rise && bit_q >= DAT_BIT) rd_q <= {rd_q[14:0], mdio_i};
        if (fall && !last) begin
          bit_q <= bit_q + 1'b1;
          if (bit_q >= CMD_BIT) sh_q <= {sh_q[30:0], 1'b0};
        end
        if (last) begin
          busy_q <= 1'b0;
          if (rd_op_q) cmd_q[15:0] <= rd_q;
        end
      end

      if (last) evt_q <= 1'b1;
      else if (evt_clr) evt_q <= 1'b0;
    end
  end

  assign cmd_rdata = cmd_q;
  assign busy      = busy_q;
  assign done_evt  = evt_q;
  assign mdc       = mdc_q;
  assign mdio_o    = (bit_q < CMD_BIT) ? 1'b1 : sh_q[31];
  assign mdio_oe   = run && !(rd_op_q && bit_q >= REL_BIT);

  // R9
  zero_div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (field_q == '0 && !accept) |=> ($stable(mdc) && $stable(bit_q)));

  // R8
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(cmd_rdata[31:16]));

  // R5
  release_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && field_q != '0 && !mdio_oe) |-> rd_op_q);

  // R4
  mdc_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc) |-> $past(busy));

  // R7
  done_with_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_evt) |-> $fell(busy));

  // R10
  busy_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_wr));
endmodule

// File: tb/mdio_frame_master_tb.sv
module mdio_frame_master_tb;
  localparam int CLK_NS = 10;

  // {command word, PHY reply, divider value}
  localparam logic [55:0] VEC [0:3] = '{
    {32'h5082_1200, 16'h0000, 8'h04},
    {32'h6186_0000, 16'hBEEF, 8'h06},
    {32'h6FFE_FFFF, 16'h0001, 8'h05},
    {32'h5AAA_A5C3, 16'h0000, 8'h02}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 1'b0, div_wr = 1'b0, evt_clr = 1'b0, mdio_i = 1'b1;
  logic [31:0] cmd_wdata = '0;
  logic [7:0]  div_wdata = '0;
  wire  [31:0] cmd_rdata;
  wire busy, done_evt, mdc, mdio_o, mdio_oe;

  int checks = 0, fails = 0, cyc = 0, cap_n = 0, last_rise = 0;
  int per_min = 0, per_max = 0;
  logic [63:0] cap_bits, cap_oe;
  logic [15:0] reply = '0;
  logic is_rd = 1'b0, ended = 1'b0;

  mdio_frame_master u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .div_wr(div_wr), .div_wdata(div_wdata), .evt_clr(evt_clr),
    .cmd_rdata(cmd_rdata), .busy(busy), .done_evt(done_evt),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_NS/2) clk = ~clk;
  always @(negedge clk) cyc++;

  always @(posedge mdc) begin
    if (cap_n < 64) begin
      cap_bits[63-cap_n] = mdio_o;
      cap_oe[63-cap_n]   = mdio_oe;
    end
    if (cap_n > 0) begin
      if (per_min == 0 || cyc - last_rise < per_min) per_min = cyc - last_rise;
      if (cyc - last_rise > per_max) per_max = cyc - last_rise;
    end
    last_rise = cyc;
    cap_n++;
  end

  always @(negedge mdc) begin
    if (is_rd && cap_n == 47) mdio_i = 1'b0;
    else if (is_rd && cap_n >= 48 && cap_n < 64) mdio_i = reply[63-cap_n];
    else mdio_i = 1'b1;
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_div(input logic [7:0] v);
    @(negedge clk); div_wr = 1'b1; div_wdata = v;
    @(negedge clk); div_wr = 1'b0;
  endtask

  task automatic start(input logic [31:0] c, input logic [15:0] r);
    cap_n = 0; per_min = 0; per_max = 0; cap_bits = '0; cap_oe = '0;
    is_rd = (c[29:28] == 2'b10); reply = r;
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = c;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
  endtask

  task automatic check_frame(input logic [31:0] c, input string tag);
    logic [63:0] exp_oe;
    chk(cap_n == 64, {tag, " R2 edge count"}, 64'(cap_n), 64);
    chk(cap_bits[63:32] == 32'hFFFF_FFFF && cap_oe[63:32] == 32'hFFFF_FFFF,
        {tag, " R2 preamble"}, cap_bits[63:32], 32'hFFFF_FFFF);
    exp_oe = (c[29:28] == 2'b10) ? 64'hFFFF_FFFF_FFFE_0000 : '1;
    chk(cap_oe == exp_oe, {tag, " R5 enable pattern"}, cap_oe, exp_oe);
    if (c[29:28] == 2'b10)
      chk(cap_bits[31:17] == c[31:17], {tag, " R3 read header"}, 64'(cap_bits[31:17]), 64'(c[31:17]));
    else
      chk(cap_bits[31:0] == c, {tag, " R3 write bits"}, 64'(cap_bits[31:0]), 64'(c));
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!ended) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!mdc && !mdio_oe && !busy && !done_evt && cmd_rdata == 0, "R1 reset",
        {mdc, mdio_oe, busy, done_evt, cmd_rdata}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 4; i++) begin
      logic [31:0] c; logic [15:0] r; logic [7:0] d; logic [31:0] exp_rd;
      c = VEC[i][55:24]; r = VEC[i][23:8]; d = VEC[i][7:0];
      set_div(d);
      start(c, r);
      // R10 busy after accept
      chk(busy, "R10 busy after write", 64'(busy), 1);
      wait_idle();
      check_frame(c, $sformatf("vec%0d", i));
      // R4 period from N = div[7:1]
      chk(per_min == 2 * int'(d >> 1) && per_max == 2 * int'(d >> 1), "R4 mdc period",
          64'(per_max), 64'(2 * int'(d >> 1)));
      exp_rd = (c[29:28] == 2'b10) ? {c[31:16], r} : c;
      chk(cmd_rdata == exp_rd, (c[29:28] == 2'b10) ? "R6 read data" : "R3 write keeps word",
          64'(cmd_rdata), 64'(exp_rd));
      // R7 completion flag
      chk(done_evt && !busy, "R7 done set", {done_evt, busy}, 2'b10);
      @(negedge clk); evt_clr = 1'b1; @(negedge clk); evt_clr = 1'b0;
      chk(!done_evt, "R7 done cleared", 64'(done_evt), 0);
    end

    // R8 write during frame ignored
    set_div(8'h04);
    start(32'h5082_1200, 16'h0);
    while (cap_n < 40) @(negedge clk);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = 32'h6FFE_0000;
    @(negedge clk); cmd_wr = 1'b0;
    chk(cmd_rdata == 32'h5082_1200, "R8 register unchanged", 64'(cmd_rdata), 64'h5082_1200);
    wait_idle();
    check_frame(32'h5082_1200, "R8");
    chk(cmd_rdata == 32'h5082_1200, "R8 after frame", 64'(cmd_rdata), 64'h5082_1200);

    // R9 zero divider holds frame
    set_div(8'h00);
    start(32'h6186_0000, 16'h1234);
    repeat (200) @(negedge clk);
    chk(busy && !mdc && !mdio_oe && cap_n == 0, "R9 held idle",
        {busy, mdc, mdio_oe, 32'(cap_n)}, 64'h4_0000_0000);
    set_div(8'h04);
    wait_idle();
    check_frame(32'h6186_0000, "R9 resumed");
    chk(cmd_rdata == 32'h6186_1234, "R9 R6 resumed read", 64'(cmd_rdata), 64'h6186_1234);

    ended = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule